// File: doc/BRIEF.md
# Glitch-Free Power-Down Clock Stopper

This block sits between a set of free-running source clocks and the pins that carry them out of a clock generator. An active-low power-down pin, asynchronous to everything, asks for all outputs to stop. The block synchronizes and qualifies that pin in the CPU reference clock domain. It then withdraws a run request from every output lane, and each lane parks its output low at the next falling edge of its own source. When every lane reports idle, the block raises a stop request for the oscillator and PLL.

When the pin returns high, the stop request is dropped first. The block then waits for a ready indication, which stands in for oscillator start and PLL lock, plus a parameterised settle interval. Only after that does it let the lanes run again. Each lane reopens its gate while its source is low, so the first pulse out is a full one. A per-output enable holds individual outputs low in normal running, and it uses the same falling-edge gate.

Top module: `pds_clock_stopper`

## Requirements
- R1: While `rst_n` is low, every `gclk` bit and `osc_stop` are low. After reset no output toggles until `osc_ready` has been high (synchronized) for `SETTLE_CYC` CPU cycles.
- R2: `pwr_dwn_n` = 0 is the request. A low that reaches the synchronizer output on fewer than `QUAL_EDGES` (default 2) consecutive CPU rising edges is ignored: outputs keep toggling and `osc_stop` stays low.
- R3: A low seen on `QUAL_EDGES` consecutive synchronized CPU rising edges starts a full shutdown, even if the pin returns high right afterwards.
- R4: A running output stops only at a falling edge of its source. Every high pulse on `gclk[i]` lasts exactly one high phase of `src_clk[i]`.
- R5: `osc_stop` rises only after every lane's gate and request stage have cleared, and no sooner than `DRAIN_MIN` CPU cycles after qualification.
- R6: While `osc_stop` is high, every `gclk` bit stays low.
- R7: When the pin returns high during a stop, `osc_stop` falls within `SYNC_STAGES`+2 CPU cycles. Outputs stay low until `osc_ready` has been high for `SETTLE_CYC` cycles.
- R8: On restart, the first high pulse of each output is a full source high phase.
- R9: `out_en[i]` = 0 holds `gclk[i]` low. Clearing or setting it takes effect only at a source falling edge, so no shortened pulse appears.
- R10: A request qualified while waiting for `osc_ready` aborts the wake-up and returns to the stopped state, with no output toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU reference clock, control domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dwn_n | input | 1 | Raw asynchronous power-down pin, low = stop |
| osc_ready | input | 1 | Oscillator/PLL ready indication, asynchronous |
| src_clk | input | N_OUT | Free-running source clocks, one per lane |
| out_en | input | N_OUT | Per-output enable, 1 = drive clock |
| gclk | output | N_OUT | Gated output clocks |
| osc_stop | output | 1 | Request to stop oscillator and VCO |

## Verification
A controller state that is wrong shows at the ports in one of three ways. The controller might enter the stopped state while a lane is still open, or it might leave the stop before `osc_ready`. Either way, `gclk` edges appear while `osc_stop` is high or while ready is low, within one source period. A wrong qualifier count shows within a few CPU cycles, as a missed or spurious `osc_stop`. A lane gate that changes while its source is high shows at once, as a high pulse shorter than the source half period. The bench times every output pulse and counts edges over windows in each phase.

// File: rtl/pds_pkg.sv
`timescale 1ns/1ps
package pds_pkg;

    typedef enum logic [1:0] {
        ST_WAKE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_OFF   = 2'd3
    } pds_state_e;

endpackage

// File: rtl/pds_sync.sv
`timescale 1ns/1ps
module pds_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                stage_q[k] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pds_qual.sv
`timescale 1ns/1ps
module pds_qual #(
    parameter int QUAL_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_low_i,
    output logic qual_o
);

    localparam int CW = $clog2(QUAL_EDGES + 1);

    typedef struct packed {
        logic [CW-1:0] run_len;
    } qual_t;

    qual_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!pin_low_i) begin
            nxt_d.run_len = '0;
        end else if (cur_q.run_len != CW'(QUAL_EDGES)) begin
            nxt_d.run_len = cur_q.run_len + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign qual_o = (cur_q.run_len == CW'(QUAL_EDGES));

    // a single high sample must drop the qualification on the next edge
    p_high_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_low_i |=> !qual_o);

    // qualification can only begin after a low sample
    p_qual_needs_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual_o) |-> $past(pin_low_i));

endmodule

// File: rtl/pds_lane.sv
`timescale 1ns/1ps
module pds_lane (
    input  logic src_clk_i,
    input  logic rst_n,
    input  logic run_req_i,
    input  logic out_en_i,
    output logic gclk_o,
    output logic busy_o
);

    logic req_q;
    logic gate_q;

    // both stages move on the source falling edge, so the gate only changes while the source is low
    always_ff @(negedge src_clk_i or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            gate_q <= 1'b0;
        end else begin
            req_q  <= run_req_i;
            gate_q <= req_q & out_en_i;
        end
    end

    assign gclk_o = src_clk_i & gate_q;
    assign busy_o = req_q | gate_q;

    p_disabled_closes_r9: assert property (@(negedge src_clk_i) disable iff (!rst_n)
        !out_en_i |=> !gate_q);

    p_no_run_closes_r4: assert property (@(negedge src_clk_i) disable iff (!rst_n)
        !req_q |=> !gate_q);

endmodule

// File: rtl/pds_ctrl.sv
`timescale 1ns/1ps
module pds_ctrl
    import pds_pkg::*;
#(
    parameter int SETTLE_CYC = 375000,
    parameter int DRAIN_MIN  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual_i,
    input  logic pin_high_i,
    input  logic ready_i,
    input  logic idle_i,
    output logic run_req_o,
    output logic osc_stop_o
);

    localparam int CMAX = (SETTLE_CYC > DRAIN_MIN) ? SETTLE_CYC : DRAIN_MIN;
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        pds_state_e    state;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            ST_WAKE: begin
                if (qual_i) begin
                    nxt_d.state = ST_DRAIN;
                    nxt_d.cnt   = '0;
                end else if (!ready_i) begin
                    nxt_d.cnt = '0;
                end else if (cur_q.cnt == CW'(SETTLE_CYC - 1)) begin
                    nxt_d.state = ST_RUN;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_RUN: begin
                if (qual_i) begin
                    nxt_d.state = ST_DRAIN;
                    nxt_d.cnt   = '0;
                end
            end
            ST_DRAIN: begin
                if (cur_q.cnt != CW'(DRAIN_MIN)) begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end else if (idle_i) begin
                    nxt_d.state = ST_OFF;
                    nxt_d.cnt   = '0;
                end
            end
            ST_OFF: begin
                if (pin_high_i) begin
                    nxt_d.state = ST_WAKE;
                    nxt_d.cnt   = '0;
                end
            end
            default: nxt_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_WAKE, cnt: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign run_req_o  = (cur_q.state == ST_RUN);
    assign osc_stop_o = (cur_q.state == ST_OFF);

    p_stop_only_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop_o |-> idle_i);

    p_run_after_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_req_o) |-> $past(ready_i));

    p_stop_not_from_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        run_req_o |=> !osc_stop_o);

endmodule

// File: rtl/pds_clock_stopper.sv
`timescale 1ns/1ps
module pds_clock_stopper #(
    parameter int N_OUT       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_EDGES  = 2,
    parameter int SETTLE_CYC  = 375000,
    parameter int DRAIN_MIN   = 16
) (
    input  logic             cpu_clk,
    input  logic             rst_n,
    input  logic             pwr_dwn_n,
    input  logic             osc_ready,
    input  logic [N_OUT-1:0] src_clk,
    input  logic [N_OUT-1:0] out_en,
    output logic [N_OUT-1:0] gclk,
    output logic             osc_stop
);

    logic             pin_s;
    logic             ready_s;
    logic             qual;
    logic             run_req;
    logic [N_OUT-1:0] busy;
    logic [N_OUT-1:0] busy_s;

    pds_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk(cpu_clk), .rst_n(rst_n), .d_i(pwr_dwn_n), .q_o(pin_s)
    );

    pds_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
        .clk(cpu_clk), .rst_n(rst_n), .d_i(osc_ready), .q_o(ready_s)
    );

    pds_sync #(.WIDTH(N_OUT), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_busy_sync (
        .clk(cpu_clk), .rst_n(rst_n), .d_i(busy), .q_o(busy_s)
    );

    pds_qual #(.QUAL_EDGES(QUAL_EDGES)) u_qual (
        .clk(cpu_clk), .rst_n(rst_n), .pin_low_i(~pin_s), .qual_o(qual)
    );

    pds_ctrl #(.SETTLE_CYC(SETTLE_CYC), .DRAIN_MIN(DRAIN_MIN)) u_ctrl (
        .clk        (cpu_clk),
        .rst_n      (rst_n),
        .qual_i     (qual),
        .pin_high_i (pin_s),
        .ready_i    (ready_s),
        .idle_i     (~|busy_s),
        .run_req_o  (run_req),
        .osc_stop_o (osc_stop)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_lane
        pds_lane u_lane (
            .src_clk_i (src_clk[g]),
            .rst_n     (rst_n),
            .run_req_i (run_req),
            .out_en_i  (out_en[g]),
            .gclk_o    (gclk[g]),
            .busy_o    (busy[g])
        );
    end

    p_quiet_when_off_r6: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        osc_stop |-> (gclk == '0));

endmodule

// File: tb/tb_pds_clock_stopper.sv
`timescale 1ns/1ps
module tb_pds_clock_stopper;

    localparam int NL     = 4;
    localparam int SETTLE = 40;
    localparam int DRAINM = 16;

    logic          cpu_clk = 1'b0;
    logic          rst_n;
    logic          pwr_dwn_n;
    logic          osc_ready;
    logic          s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
    logic [NL-1:0] src_clk;
    logic [NL-1:0] out_en;
    logic [NL-1:0] gclk;
    logic          osc_stop;

    int n_chk = 0;
    int n_bad = 0;
    bit osc_seen = 1'b0;

    assign src_clk = {s3, s2, s1, s0};

    always #4 cpu_clk = ~cpu_clk;
    initial forever #5  s0 = ~s0;
    initial forever #7  s1 = ~s1;
    initial forever #11 s2 = ~s2;
    initial forever #15 s3 = ~s3;

    pds_clock_stopper #(
        .N_OUT(NL), .SYNC_STAGES(2), .QUAL_EDGES(2),
        .SETTLE_CYC(SETTLE), .DRAIN_MIN(DRAINM)
    ) dut (
        .cpu_clk(cpu_clk), .rst_n(rst_n), .pwr_dwn_n(pwr_dwn_n),
        .osc_ready(osc_ready), .src_clk(src_clk), .out_en(out_en),
        .gclk(gclk), .osc_stop(osc_stop)
    );

    function automatic real half_of(int k);
        case (k)
            0: return 5.0;
            1: return 7.0;
            2: return 11.0;
            default: return 15.0;
        endcase
    endfunction

    // per-lane monitors: edge count, pulse width, edges while stopped
    for (genvar gi = 0; gi < NL; gi++) begin : mon
        int unsigned edge_cnt  = 0;
        int unsigned width_ok  = 0;
        int unsigned width_bad = 0;
        int unsigned off_rise  = 0;
        realtime     t_rise    = 0;
        bit          have_rise = 1'b0;
        always @(posedge gclk[gi]) begin
            edge_cnt++;
            t_rise    = $realtime;
            have_rise = 1'b1;
            if (osc_stop) off_rise++;
        end
        always @(negedge gclk[gi]) begin
            if (have_rise) begin
                realtime w;
                w = $realtime - t_rise;
                if (w > half_of(gi) - 0.01 && w < half_of(gi) + 0.01) width_ok++;
                else begin
                    width_bad++;
                    $display("FAIL R4/R8 lane %0d pulse width actual=%0t expected=%0.1f", gi, w, half_of(gi));
                end
                have_rise = 1'b0;
            end
        end
    end

    always @(posedge osc_stop) osc_seen = 1'b1;

    function automatic int unsigned edges_of(int k);
        case (k)
            0: return mon[0].edge_cnt;
            1: return mon[1].edge_cnt;
            2: return mon[2].edge_cnt;
            default: return mon[3].edge_cnt;
        endcase
    endfunction

    function automatic int unsigned all_edges();
        return edges_of(0) + edges_of(1) + edges_of(2) + edges_of(3);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge cpu_clk);
    endtask

    task automatic wait_stop(input int limit, output int took);
        took = 0;
        while (!osc_stop && took < limit) begin
            @(negedge cpu_clk);
            took++;
        end
    endtask

    task automatic t_reset();
        cyc(6);
        check(gclk == '0, "R1", "gclk in reset", gclk, 0);
        check(osc_stop == 1'b0, "R1", "osc_stop in reset", osc_stop, 0);
        check(all_edges() == 0, "R1", "edges in reset", all_edges(), 0);
    endtask

    task automatic t_startup();
        int unsigned e0;
        rst_n = 1'b1;
        cyc(30);
        check(all_edges() == 0, "R1", "edges without ready", all_edges(), 0);
        osc_ready = 1'b1;
        e0 = all_edges();
        cyc(SETTLE - 4);
        check(all_edges() == e0, "R7", "edges during settle", all_edges() - e0, 0);
        cyc(30);
        for (int k = 0; k < NL; k++)
            check(edges_of(k) > 0, "R1", "lane running after settle", edges_of(k), 1);
    endtask

    task automatic t_glitch();
        int unsigned e0;
        osc_seen = 1'b0;
        @(negedge cpu_clk);
        #1 pwr_dwn_n = 1'b0;
        #2 pwr_dwn_n = 1'b1;
        cyc(5);
        pwr_dwn_n = 1'b0;
        @(negedge cpu_clk);
        pwr_dwn_n = 1'b1;
        e0 = all_edges();
        cyc(60);
        check(osc_seen == 1'b0, "R2", "osc_stop after one-edge glitch", osc_seen, 0);
        for (int k = 0; k < NL; k++)
            check(edges_of(k) > 0 && all_edges() - e0 > 20, "R2", "outputs still toggling", all_edges() - e0, 21);
    endtask

    task automatic t_powerdown();
        int took;
        int unsigned e0;
        pwr_dwn_n = 1'b0;
        wait_stop(200, took);
        check(osc_stop == 1'b1, "R5", "osc_stop after held request", osc_stop, 1);
        check(took >= DRAINM, "R5", "cycles before osc_stop", took, DRAINM);
        osc_ready = 1'b0;
        e0 = all_edges();
        cyc(100);
        check(all_edges() == e0, "R6", "edges while stopped", all_edges() - e0, 0);
        check(gclk == '0 && osc_stop, "R6", "outputs low while stopped", gclk, 0);
    endtask

    task automatic t_resume();
        int unsigned e0;
        e0 = all_edges();
        pwr_dwn_n = 1'b1;
        cyc(4);
        check(osc_stop == 1'b0, "R7", "osc_stop after release", osc_stop, 0);
        cyc(50);
        check(all_edges() == e0, "R7", "edges before ready", all_edges() - e0, 0);
        osc_ready = 1'b1;
        cyc(SETTLE + 30);
        for (int k = 0; k < NL; k++)
            check(edges_of(k) > 0 && all_edges() > e0 + 10, "R8", "lanes restarted", all_edges() - e0, 11);
    endtask

    task automatic t_two_edge();
        int took;
        int unsigned e0;
        osc_seen = 1'b0;
        pwr_dwn_n = 1'b0;
        cyc(2);
        pwr_dwn_n = 1'b1;
        took = 0;
        while (!osc_seen && took < 200) begin
            @(negedge cpu_clk);
            took++;
        end
        check(osc_seen == 1'b1, "R3", "stop from two-edge request", osc_seen, 1);
        cyc(SETTLE + 40);
        e0 = all_edges();
        cyc(20);
        check(all_edges() > e0, "R3", "self-wake after short request", all_edges() - e0, 1);
    endtask

    task automatic t_enable();
        int unsigned e1, e0;
        @(negedge cpu_clk);
        #1.3 out_en[1] = 1'b0;
        cyc(20);
        e1 = edges_of(1);
        e0 = edges_of(0);
        cyc(40);
        check(edges_of(1) == e1, "R9", "disabled lane edges", edges_of(1) - e1, 0);
        check(edges_of(0) > e0, "R9", "enabled lane edges", edges_of(0) - e0, 1);
        check(gclk[1] == 1'b0, "R9", "disabled lane level", gclk[1], 0);
        #2.1 out_en[1] = 1'b1;
        e1 = edges_of(1);
        cyc(30);
        check(edges_of(1) > e1, "R9", "re-enabled lane edges", edges_of(1) - e1, 1);
    endtask

    task automatic t_wake_abort();
        int took;
        int unsigned e0;
        pwr_dwn_n = 1'b0;
        wait_stop(200, took);
        osc_ready = 1'b0;
        e0 = all_edges();
        pwr_dwn_n = 1'b1;
        cyc(6);
        check(osc_stop == 1'b0, "R10", "left stop before abort", osc_stop, 0);
        pwr_dwn_n = 1'b0;
        wait_stop(100, took);
        check(osc_stop == 1'b1, "R10", "stop again after aborted wake", osc_stop, 1);
        check(all_edges() == e0, "R10", "edges during aborted wake", all_edges() - e0, 0);
        pwr_dwn_n = 1'b1;
        osc_ready = 1'b1;
        cyc(SETTLE + 30);
        check(all_edges() > e0, "R10", "run after final wake", all_edges() - e0, 1);
    endtask

    task automatic t_widths();
        for (int k = 0; k < NL; k++) begin
            int unsigned bad, good, off;
            case (k)
                0: begin bad = mon[0].width_bad; good = mon[0].width_ok; off = mon[0].off_rise; end
                1: begin bad = mon[1].width_bad; good = mon[1].width_ok; off = mon[1].off_rise; end
                2: begin bad = mon[2].width_bad; good = mon[2].width_ok; off = mon[2].off_rise; end
                default: begin bad = mon[3].width_bad; good = mon[3].width_ok; off = mon[3].off_rise; end
            endcase
            check(bad == 0, "R4", "short pulses", bad, 0);
            check(good > 0, "R8", "full pulses measured", good, 1);
            check(off == 0, "R6", "rises while stopped", off, 0);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        rst_n     = 1'b0;
        pwr_dwn_n = 1'b1;
        osc_ready = 1'b0;
        out_en    = '1;
        t_reset();
        t_startup();
        t_glitch();
        t_powerdown();
        t_resume();
        t_two_edge();
        t_enable();
        t_wake_abort();
        t_widths();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge cpu_clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=done");
        summary();
        $finish;
    end

endmodule